// File: doc/BRIEF.md
# Operand Bypass Selector with Load-Use Interlock

This combinational unit steers the two ALU operands of a five-stage, in-order 32-bit integer pipeline. The unit compares the source register numbers of the instruction in execute with the destinations of the two older instructions. For each operand it produces a 2-bit code that tells the operand multiplexer where to take the value from. The candidate sources are the register-file value read in decode, the result held just after execute, and the result held just after the memory stage.

The unit also drives a single interlock signal. This signal is raised when the instruction in execute is a load and the instruction in decode needs the register that the load will write. While the signal is high, the surrounding pipeline holds the program counter and the fetch/decode register and sends a bubble into execute. The load itself moves on. The register file writes in the first half of a cycle and reads in the second half, so a producer three instructions ahead needs no bypass.

Top module: `bypass_interlock`

## Requirements
- R1: Each operand select is a 2-bit code: 0 takes the decode-read value, 1 takes the post-execute result, 2 takes the post-memory result. The code 3 is never produced.
- R2: Operand A gets code 1 when the post-execute stage writes a register whose number equals the execute-stage first source. Operand B gets code 1 under the same rule with the execute-stage second source.
- R3: An operand gets code 2 only when the post-memory stage writes a matching register and the post-execute stage does not. When both stages match, code 1 wins.
- R4: The interlock is high exactly when the execute-stage instruction is a load with write-enable set and its destination equals the first or second decode-stage source. A non-load never raises it.
- R5: With the hard-zero option set (the default), register number 0 never produces a bypass or an interlock, even when a stage claims to write it.
- R6: A stage whose write-enable is low never produces a match, whatever its destination field holds.
- R7: In a pipeline whose register file writes before it reads, the operands that the selects deliver equal the in-order architectural values. This holds for ALU dependencies at distances 1, 2 and 3, for a use right after a load, and for reads of register 0.
- R8: A load followed at once by a dependent instruction costs exactly one interlock cycle. A dependent instruction two slots after a load costs none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs1 | input | REG_W | First source register of the decode-stage instruction |
| id_rs2 | input | REG_W | Second source register of the decode-stage instruction |
| ex_rs1 | input | REG_W | First source register of the execute-stage instruction |
| ex_rs2 | input | REG_W | Second source register of the execute-stage instruction |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| xm_dst | input | REG_W | Destination held in the post-execute pipeline register |
| xm_wen | input | 1 | Post-execute instruction writes a register |
| mw_dst | input | REG_W | Destination held in the post-memory pipeline register |
| mw_wen | input | 1 | Post-memory instruction writes a register |
| sel_a | output | 2 | Operand A source code (0 decode value, 1 post-execute, 2 post-memory) |
| sel_b | output | 2 | Operand B source code, same encoding |
| stall | output | 1 | Load-use interlock: hold PC and fetch/decode, bubble into execute |

## Verification
Two functions can act on the same cycle. Both bypass levels can match one operand together, and an interlock from the load in execute can coincide with a bypass of the instruction in execute. The random phase draws register numbers from a small pool so that double matches, matches on both operands, and interlocks occurring alongside forwarding happen often. Each case is judged against bench functions written from R2 to R6. The cycle model then runs a load-use pair next to ALU chains. It checks that the operand values picked through the selects equal the in-order results on every cycle, and that the interlock lasts exactly one cycle.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
   typedef enum logic [1:0] {
      OPSEL_RF   = 2'd0,
      OPSEL_EXM  = 2'd1,
      OPSEL_MWB  = 2'd2,
      OPSEL_RSVD = 2'd3
   } opsel_e;
endpackage

// File: rtl/byp_dest_match.sv
// One producer/consumer comparison: does a writing stage supply this source?
module byp_dest_match #(
   parameter int REG_W     = 5,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic             wen,
   input  logic [REG_W-1:0] dst,
   input  logic [REG_W-1:0] src,
   output logic             hit
);
   logic same;
   assign same = (dst == src);

   generate
      if (HARD_ZERO) begin : g_zero_excluded
         assign hit = wen && same && (dst != '0);
      end else begin : g_zero_plain
         assign hit = wen && same;
      end
   endgenerate
endmodule

// File: rtl/byp_operand_sel.sv
// Bypass priority for one ALU operand: the newer result wins.
module byp_operand_sel
   import bypass_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic             [REG_W-1:0] src,
   input  logic                         xm_wen,
   input  logic             [REG_W-1:0] xm_dst,
   input  logic                         mw_wen,
   input  logic             [REG_W-1:0] mw_dst,
   output opsel_e                       sel
);
   logic near_hit;
   logic far_hit;

   byp_dest_match #(.REG_W(REG_W), .HARD_ZERO(HARD_ZERO)) u_near (
      .wen (xm_wen),
      .dst (xm_dst),
      .src (src),
      .hit (near_hit)
   );

   byp_dest_match #(.REG_W(REG_W), .HARD_ZERO(HARD_ZERO)) u_far (
      .wen (mw_wen),
      .dst (mw_dst),
      .src (src),
      .hit (far_hit)
   );

   always_comb begin
      if (near_hit)      sel = OPSEL_EXM;
      else if (far_hit)  sel = OPSEL_MWB;
      else               sel = OPSEL_RF;
   end
endmodule

// File: rtl/byp_load_use.sv
// Interlock when a load in execute feeds any source of the decode instruction.
module byp_load_use #(
   parameter int REG_W     = 5,
   parameter bit HARD_ZERO = 1'b1,
   parameter int NUM_SRC   = 2
) (
   input  logic                            ld,
   input  logic                            wen,
   input  logic [REG_W-1:0]                dst,
   input  logic [NUM_SRC-1:0][REG_W-1:0]   id_src,
   output logic                            stall
);
   logic [NUM_SRC-1:0] src_hit;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         byp_dest_match #(.REG_W(REG_W), .HARD_ZERO(HARD_ZERO)) u_cmp (
            .wen (wen),
            .dst (dst),
            .src (id_src[s]),
            .hit (src_hit[s])
         );
      end
   endgenerate

   assign stall = ld && (|src_hit);
endmodule

// File: rtl/bypass_interlock.sv
module bypass_interlock
   import bypass_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit HARD_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] id_rs1,
   input  logic [REG_W-1:0] id_rs2,
   input  logic [REG_W-1:0] ex_rs1,
   input  logic [REG_W-1:0] ex_rs2,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic [REG_W-1:0] xm_dst,
   input  logic             xm_wen,
   input  logic [REG_W-1:0] mw_dst,
   input  logic             mw_wen,
   output logic [1:0]       sel_a,
   output logic [1:0]       sel_b,
   output logic             stall
);
   localparam int NUM_OPND = 2;

   generate
      if (REG_W < 2 || REG_W > 8) begin : g_bad_width
         $error("bypass_interlock: REG_W must lie in 2..8");
      end
   endgenerate

   logic   [NUM_OPND-1:0][REG_W-1:0] ex_src;
   logic   [NUM_OPND-1:0][REG_W-1:0] id_src;
   opsel_e [NUM_OPND-1:0]            opnd_sel;

   assign ex_src = {ex_rs2, ex_rs1};
   assign id_src = {id_rs2, id_rs1};

   generate
      for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
         byp_operand_sel #(.REG_W(REG_W), .HARD_ZERO(HARD_ZERO)) u_sel (
            .src    (ex_src[k]),
            .xm_wen (xm_wen),
            .xm_dst (xm_dst),
            .mw_wen (mw_wen),
            .mw_dst (mw_dst),
            .sel    (opnd_sel[k])
         );
      end
   endgenerate

   assign sel_a = opnd_sel[0];
   assign sel_b = opnd_sel[1];

   byp_load_use #(.REG_W(REG_W), .HARD_ZERO(HARD_ZERO), .NUM_SRC(NUM_OPND)) u_lu (
      .ld     (ex_load),
      .wen    (ex_wen),
      .dst    (ex_dst),
      .id_src (id_src),
      .stall  (stall)
   );
endmodule

// File: rtl/bypass_interlock_chk.sv
module bypass_interlock_chk #(
   parameter int REG_W     = 5,
   parameter bit HARD_ZERO = 1'b1
) (
   input logic [REG_W-1:0] id_rs1,
   input logic [REG_W-1:0] id_rs2,
   input logic [REG_W-1:0] ex_rs1,
   input logic [REG_W-1:0] ex_rs2,
   input logic [REG_W-1:0] ex_dst,
   input logic             ex_wen,
   input logic             ex_load,
   input logic [REG_W-1:0] xm_dst,
   input logic             xm_wen,
   input logic [REG_W-1:0] mw_dst,
   input logic             mw_wen,
   input logic [1:0]       sel_a,
   input logic [1:0]       sel_b,
   input logic             stall
);
   logic zero_ok_a;
   logic zero_ok_b;
   assign zero_ok_a = !HARD_ZERO || (ex_rs1 != '0);
   assign zero_ok_b = !HARD_ZERO || (ex_rs2 != '0);

   always_comb begin
      p_sel_legal_r1: assert (sel_a != 2'd3 && sel_b != 2'd3)
         else $error("select code 3 driven");

      if (xm_wen && xm_dst == ex_rs1 && zero_ok_a) begin
         p_near_a_r2: assert (sel_a == 2'd1) else $error("operand A missed near bypass");
      end
      if (xm_wen && xm_dst == ex_rs2 && zero_ok_b) begin
         p_near_b_r2: assert (sel_b == 2'd1) else $error("operand B missed near bypass");
      end

      if (sel_a == 2'd2) begin
         p_far_a_r3: assert (mw_wen && mw_dst == ex_rs1 && !(xm_wen && xm_dst == ex_rs1))
            else $error("operand A far bypass without sole far match");
      end
      if (sel_b == 2'd2) begin
         p_far_b_r3: assert (mw_wen && mw_dst == ex_rs2 && !(xm_wen && xm_dst == ex_rs2))
            else $error("operand B far bypass without sole far match");
      end

      if (stall) begin
         p_stall_cause_r4: assert (ex_load && ex_wen && (ex_dst == id_rs1 || ex_dst == id_rs2))
            else $error("interlock without load-use match");
      end

      if (HARD_ZERO) begin
         if (ex_rs1 == '0) begin
            p_zero_a_r5: assert (sel_a == 2'd0) else $error("register 0 bypassed on A");
         end
         if (ex_rs2 == '0) begin
            p_zero_b_r5: assert (sel_b == 2'd0) else $error("register 0 bypassed on B");
         end
         if (stall) begin
            p_zero_stall_r5: assert (ex_dst != '0) else $error("interlock on register 0");
         end
      end

      if (!xm_wen && !mw_wen) begin
         p_no_writer_r6: assert (sel_a == 2'd0 && sel_b == 2'd0)
            else $error("bypass with no writing stage");
      end
      if (!ex_wen) begin
         p_no_ld_write_r6: assert (!stall) else $error("interlock from non-writing load");
      end
   end
endmodule

bind bypass_interlock bypass_interlock_chk #(.REG_W(REG_W), .HARD_ZERO(HARD_ZERO)) u_chk (
   .id_rs1 (id_rs1), .id_rs2 (id_rs2),
   .ex_rs1 (ex_rs1), .ex_rs2 (ex_rs2),
   .ex_dst (ex_dst), .ex_wen (ex_wen), .ex_load (ex_load),
   .xm_dst (xm_dst), .xm_wen (xm_wen),
   .mw_dst (mw_dst), .mw_wen (mw_wen),
   .sel_a  (sel_a),  .sel_b  (sel_b),  .stall (stall)
);

// File: tb/bypass_interlock_tb.sv
`timescale 1ns/1ps
module bypass_interlock_tb;
   localparam int RW = 5;
   localparam int OP_ADD = 0, OP_LD = 1, OP_NOP = 2;
   localparam int NPROG = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_dst, xm_dst, mw_dst;
   logic ex_wen, ex_load, xm_wen, mw_wen;
   logic [1:0] sel_a, sel_b;
   logic stall;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   bypass_interlock #(.REG_W(RW), .HARD_ZERO(1'b1)) u_dut (
      .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
      .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
      .xm_dst(xm_dst), .xm_wen(xm_wen), .mw_dst(mw_dst), .mw_wen(mw_wen),
      .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected select per R1/R2/R3/R5/R6
   function automatic logic [1:0] exp_sel(input logic [RW-1:0] src, input logic xw, input logic [RW-1:0] xd,
                                          input logic mwe, input logic [RW-1:0] md);
      if (xw && xd != 0 && xd == src) return 2'd1;
      if (mwe && md != 0 && md == src) return 2'd2;
      return 2'd0;
   endfunction

   // expected interlock per R4/R5/R6
   function automatic logic exp_stall(input logic ld, input logic w, input logic [RW-1:0] d,
                                      input logic [RW-1:0] s1, input logic [RW-1:0] s2);
      return ld && w && d != 0 && (d == s1 || d == s2);
   endfunction

   task automatic drive(input logic [RW-1:0] a1, a2, e1, e2, ed, input logic ew, el,
                        input logic [RW-1:0] xd, input logic xw, input logic [RW-1:0] md, input logic mwe);
      id_rs1 = a1; id_rs2 = a2; ex_rs1 = e1; ex_rs2 = e2; ex_dst = ed;
      ex_wen = ew; ex_load = el; xm_dst = xd; xm_wen = xw; mw_dst = md; mw_wen = mwe;
   endtask

   task automatic judge(input string tag);
      logic [1:0] ea, eb;
      logic es;
      #1;
      ea = exp_sel(ex_rs1, xm_wen, xm_dst, mw_wen, mw_dst);
      eb = exp_sel(ex_rs2, xm_wen, xm_dst, mw_wen, mw_dst);
      es = exp_stall(ex_load, ex_wen, ex_dst, id_rs1, id_rs2);
      check(sel_a == ea, {tag, " sel_a"}, 32'(sel_a), 32'(ea));
      check(sel_b == eb, {tag, " sel_b"}, 32'(sel_b), 32'(eb));
      check(stall == es, {tag, " stall"}, 32'(stall), 32'(es));
   endtask

   function automatic logic [RW-1:0] pick_reg();
      if ($urandom_range(0, 7) == 0) return RW'($urandom_range(0, 31));
      return RW'($urandom_range(0, 3));
   endfunction

   // ---------------- cycle model (R7, R8) ----------------
   typedef struct {
      logic v; int op; logic [RW-1:0] rd, rs1, rs2; logic [31:0] imm;
      int idx; logic [31:0] va, vb, res;
   } slot_t;

   slot_t prog [NPROG];
   logic [31:0] exp_a [NPROG];
   logic [31:0] exp_b [NPROG];

   function automatic logic [31:0] memf(input logic [31:0] adr);
      return adr * 3 + 7;
   endfunction

   function automatic slot_t mk(input int op, input int rd, input int r1, input int r2, input int imm);
      slot_t s;
      s.v = 1'b1; s.op = op; s.rd = RW'(rd); s.rs1 = RW'(r1); s.rs2 = RW'(r2);
      s.imm = 32'(imm); s.idx = 0; s.va = '0; s.vb = '0; s.res = '0;
      return s;
   endfunction

   function automatic slot_t bubble();
      slot_t s = mk(OP_NOP, 0, 0, 0, 0);
      s.v = 1'b0;
      return s;
   endfunction

   function automatic logic wr(input slot_t s);
      return s.v && s.op != OP_NOP;
   endfunction

   task automatic run_model();
      logic [31:0] rf [32];
      logic [31:0] ar [32];
      slot_t fd, de, em, mw, de_n, em_n, mw_n;
      logic [31:0] opa, opb;
      int pc = 0;
      int stalls = 0;
      int stall_at = -1;
      for (int i = 0; i < 32; i++) begin
         rf[i] = (i == 0) ? 32'd0 : 32'(i * 11 + 1);
         ar[i] = rf[i];
      end
      // R7 load-use, then dependent uses
      prog[0]  = mk(OP_LD,  2, 1, 0, 4);
      prog[1]  = mk(OP_ADD, 3, 2, 5, 0);
      prog[2]  = mk(OP_ADD, 4, 6, 2, 0);
      prog[3]  = mk(OP_ADD, 7, 2, 2, 0);
      // R7 ALU chain: distances 1, 2, 3
      prog[4]  = mk(OP_ADD, 1, 8, 9, 0);
      prog[5]  = mk(OP_ADD, 10, 1, 8, 0);
      prog[6]  = mk(OP_ADD, 11, 9, 1, 0);
      prog[7]  = mk(OP_ADD, 12, 1, 1, 0);
      // R5 writes to register 0 must read back as zero
      prog[8]  = mk(OP_ADD, 0, 8, 9, 0);
      prog[9]  = mk(OP_ADD, 13, 0, 8, 0);
      prog[10] = mk(OP_ADD, 14, 9, 0, 0);
      // R8 load with use two slots later: no interlock
      prog[11] = mk(OP_LD,  15, 8, 0, 2);
      prog[12] = mk(OP_ADD, 16, 9, 9, 0);
      prog[13] = mk(OP_ADD, 17, 15, 9, 0);
      // R3 both stages write the same register, newest wins
      prog[14] = mk(OP_ADD, 18, 8, 8, 0);
      prog[15] = mk(OP_ADD, 18, 9, 9, 0);
      prog[16] = mk(OP_ADD, 19, 18, 18, 0);
      for (int i = 17; i < NPROG; i++) prog[i] = mk(OP_NOP, 0, 0, 0, 0);
      for (int i = 0; i < NPROG; i++) begin
         prog[i].idx = i;
         exp_a[i] = ar[prog[i].rs1];
         exp_b[i] = ar[prog[i].rs2];
         if (prog[i].op == OP_ADD && prog[i].rd != 0) ar[prog[i].rd] = exp_a[i] + exp_b[i];
         if (prog[i].op == OP_LD && prog[i].rd != 0) ar[prog[i].rd] = memf(exp_a[i] + prog[i].imm);
      end

      fd = bubble(); de = bubble(); em = bubble(); mw = bubble();
      for (int cyc = 0; cyc < NPROG + 8; cyc++) begin
         @(negedge clk);
         drive(fd.rs1, fd.rs2, de.rs1, de.rs2, de.rd, wr(de), de.v && de.op == OP_LD,
               em.rd, wr(em), mw.rd, wr(mw));
         #1;
         check(stall == exp_stall(de.v && de.op == OP_LD, wr(de), de.rd, fd.rs1, fd.rs2),
               "R4 model stall", 32'(stall), 32'(exp_stall(de.v && de.op == OP_LD, wr(de), de.rd, fd.rs1, fd.rs2)));
         if (stall) begin
            stalls++;
            stall_at = fd.idx;
         end
         opa = (sel_a == 2'd1) ? em.res : (sel_a == 2'd2) ? mw.res : de.va;
         opb = (sel_b == 2'd1) ? em.res : (sel_b == 2'd2) ? mw.res : de.vb;
         if (wr(de)) begin
            check(opa == exp_a[de.idx], $sformatf("R7 operand A of instr %0d", de.idx), opa, exp_a[de.idx]);
            check(opb == exp_b[de.idx], $sformatf("R7 operand B of instr %0d", de.idx), opb, exp_b[de.idx]);
         end
         // advance one clock: writeback first, then decode reads
         if (wr(mw) && mw.rd != 0) rf[mw.rd] = mw.res;
         mw_n = em;
         if (em.v && em.op == OP_LD) mw_n.res = memf(em.res);
         em_n = de;
         em_n.res = (de.op == OP_LD) ? opa + de.imm : opa + opb;
         if (stall) begin
            de_n = bubble();
         end else begin
            de_n = fd;
            de_n.va = rf[fd.rs1];
            de_n.vb = rf[fd.rs2];
            fd = (pc < NPROG) ? prog[pc] : bubble();
            pc++;
         end
         mw = mw_n; em = em_n; de = de_n;
      end
      check(stalls == 1, "R8 interlock cycle count", 32'(stalls), 32'd1);
      check(stall_at == 1, "R8 interlock held the dependent of the load", 32'(stall_at), 32'd1);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      judge("R1 reset state");
      rst_n = 1'b1;

      // directed corners
      @(negedge clk); drive(0, 0, 5, 6, 0, 0, 0, 5, 1, 5, 1); judge("R3 both stages match A, near wins");
      @(negedge clk); drive(0, 0, 5, 5, 0, 0, 0, 9, 1, 5, 1); judge("R3 far only on A and B");
      @(negedge clk); drive(0, 0, 7, 3, 0, 0, 0, 7, 1, 3, 1); judge("R2 near on A, far on B");
      @(negedge clk); drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1); judge("R5 register 0 written by both stages");
      @(negedge clk); drive(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0); judge("R5 load to register 0");
      @(negedge clk); drive(4, 0, 4, 4, 4, 0, 1, 4, 0, 4, 1); judge("R6 near stage not writing");
      @(negedge clk); drive(4, 4, 4, 4, 4, 0, 1, 4, 0, 4, 0); judge("R6 no stage writing");
      @(negedge clk); drive(1, 9, 2, 3, 9, 1, 1, 0, 0, 0, 0); judge("R4 load matches decode rs2");
      @(negedge clk); drive(9, 9, 2, 3, 9, 1, 0, 0, 0, 0, 0); judge("R4 non-load match, no interlock");
      @(negedge clk); drive(9, 1, 9, 9, 9, 1, 1, 9, 1, 9, 1); judge("R4 interlock together with near bypass");
      @(negedge clk); drive(31, 31, 31, 31, 31, 1, 1, 31, 1, 30, 1); judge("R2 top register number");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         drive(pick_reg(), pick_reg(), pick_reg(), pick_reg(), pick_reg(),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               pick_reg(), 1'($urandom_range(0, 1)), pick_reg(), 1'($urandom_range(0, 1)));
         judge("R1/R2/R3/R4/R5/R6 random");
      end

      run_model();

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(5 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule